// File: doc/BRIEF.md
# Fracturable Multi-Mode RAM

This block wraps one physical simple dual-port memory array (one write port, one read port, `CORE_AW` row-address bits, `DW` bits per row) and presents it as one of several logical memories. A static configuration input picks the mode. Mode `k` cuts every physical row into `2^k` equal lanes of `floor(DW / 2^k)` bits. The logical memory is therefore `2^(CORE_AW+k)` entries deep, and each step halves the width while doubling the depth. The widest mode is `k = 0`, which uses whole rows. The narrowest mode is `MAX_MODE = AW - CORE_AW`. Its width need not be one bit; the parameter `AW` sets it.

The logical address is cut into a row index and a lane index. A write updates only the addressed lane, using a per-bit write enable on the array. A read returns the addressed lane right-aligned one cycle later, with zero in every bit above the lane width. When `DW` is not a power of two, the lane width rounds down and the depth stays a power of two. Some high bits of each row then belong to no lane in the narrower modes. A mode code beyond the narrowest legal mode is treated as that mode, and an error flag is raised.

Top module: `fracram_top`

## Requirements
- R1: In mode k the logical memory is W_k = floor(DW / 2^k) bits wide and 2^(CORE_AW+k) entries deep. Address bits at positions CORE_AW+k and above are ignored.
- R2: In mode k, logical address bits [CORE_AW+k-1:k] select the physical row and bits [k-1:0] select the lane. Lane j occupies row bits [j*W_k + W_k-1 : j*W_k], so lane 0 sits in the least significant bits.
- R3: A write in mode k changes exactly the W_k bits of the selected lane to wr_data[W_k-1:0]. Every other bit of that row and of all other rows keeps its value.
- R4: A read issued with rd_en high at a clock edge shows its data on rd_data after that edge. While rd_en is low, rd_data holds its value as long as cfg_mode does not change.
- R5: rd_data bits at positions W_k and above are always zero.
- R6: Row bits at positions 2^k * W_k and above are never modified by writes in mode k.
- R7: A read and a write to the same logical address at the same edge return the contents from before the write.
- R8: A cfg_mode value above AW-CORE_AW is handled exactly as mode AW-CORE_AW. mode_err is a registered flag: after each edge out of reset it shows whether cfg_mode was above AW-CORE_AW at that edge.
- R9: While rst is high at an edge, rd_data and mode_err are cleared to zero after that edge, and no write takes effect.
- R10: With wr_en low, no bit of the memory changes, whatever wr_addr and wr_data carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | MODE_W | Static split mode k (0 = full width) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Logical write address |
| wr_data | input | DW | Write data, low W_k bits used |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Logical read address |
| rd_data | output | DW | Read lane, right-aligned, upper bits zero |
| mode_err | output | 1 | Registered flag for an illegal mode code |

## Verification
The bench uses a 12-bit, 16-row default so that the narrowest mode leaves four row bits that belong to no lane. It writes single lanes in narrow modes and then reads whole rows in mode 0. This exposes a design that writes a whole row, shifts a lane to the wrong position, or touches the unused top bits. Same-address read/write collisions catch a design that forwards the new data. Reads with high address bits set catch a row index taken from the wrong bits. An illegal mode code checks both the clamp and the one-cycle flag; a design that wraps the mode code instead of clamping it returns data of the wrong width.

// File: rtl/fracram_pkg.sv
package fracram_pkg;

  // Bits per lane when a row of dw bits is cut into 2^k lanes.
  function automatic int lane_width(input int dw, input int k);
    return dw >> k;
  endfunction

  // Bits needed to hold values 0..n-1, at least one.
  function automatic int index_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/fracram_addr_split.sv
module fracram_addr_split #(
  parameter int AW      = 7,
  parameter int CORE_AW = 4,
  parameter int EW      = 2,
  parameter int LW      = 3
) (
  input  logic [AW-1:0]      addr,
  input  logic [EW-1:0]      mode,
  output logic [CORE_AW-1:0] row,
  output logic [LW-1:0]      lane
);

  logic [AW-1:0] shifted;
  logic [AW-1:0] low_mask;

  always_comb begin
    shifted  = addr >> mode;
    low_mask = (AW'(1) << mode) - AW'(1);
    row      = shifted[CORE_AW-1:0];
    lane     = LW'(addr & low_mask);
  end

endmodule

// File: rtl/fracram_wr_lane.sv
module fracram_wr_lane
  import fracram_pkg::*;
#(
  parameter int DW       = 12,
  parameter int MAX_MODE = 3,
  parameter int EW       = 2,
  parameter int LW       = 3
) (
  input  logic          wr_en,
  input  logic [EW-1:0] mode,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] bit_we,
  output logic [DW-1:0] bit_data
);

  localparam int NMODES = MAX_MODE + 1;

  logic [DW-1:0] cand_we   [NMODES];
  logic [DW-1:0] cand_data [NMODES];

  for (genvar k = 0; k < NMODES; k++) begin : g_mode
    localparam int W = lane_width(DW, k);
    localparam logic [DW-1:0] ONES = {DW{1'b1}} >> (DW - W);
    assign cand_we[k]   = ONES << (int'(lane) * W);
    assign cand_data[k] = (wr_data & ONES) << (int'(lane) * W);
  end

  always_comb begin
    bit_we   = '0;
    bit_data = '0;
    for (int k = 0; k < NMODES; k++) begin
      if (int'(mode) == k) begin
        bit_we   = cand_we[k];
        bit_data = cand_data[k];
      end
    end
    if (!wr_en) bit_we = '0;
  end

endmodule

// File: rtl/fracram_rd_lane.sv
module fracram_rd_lane
  import fracram_pkg::*;
#(
  parameter int DW       = 12,
  parameter int MAX_MODE = 3,
  parameter int EW       = 2,
  parameter int LW       = 3
) (
  input  logic [EW-1:0] mode,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] row_data,
  output logic [DW-1:0] lane_data
);

  localparam int NMODES = MAX_MODE + 1;

  logic [DW-1:0] cand [NMODES];

  for (genvar k = 0; k < NMODES; k++) begin : g_mode
    localparam int W = lane_width(DW, k);
    localparam logic [DW-1:0] ONES = {DW{1'b1}} >> (DW - W);
    assign cand[k] = (row_data >> (int'(lane) * W)) & ONES;
  end

  always_comb begin
    lane_data = '0;
    for (int k = 0; k < NMODES; k++) begin
      if (int'(mode) == k) lane_data = cand[k];
    end
  end

endmodule

// File: rtl/fracram_core.sv
module fracram_core #(
  parameter int CORE_AW = 4,
  parameter int DW      = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DW-1:0]      bit_we,
  input  logic [CORE_AW-1:0] waddr,
  input  logic [DW-1:0]      wdata,
  input  logic               re,
  input  logic [CORE_AW-1:0] raddr,
  output logic [DW-1:0]      rq
);

  localparam int DEPTH = 1 << CORE_AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < DW; b++) begin
      if (bit_we[b]) mem[waddr][b] <= wdata[b];
    end
  end

  // Registered read: old contents on a same-row collision.
  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= mem[raddr];
  end

endmodule

// File: rtl/fracram_top.sv
module fracram_top
  import fracram_pkg::*;
#(
  parameter int CORE_AW = 4,
  parameter int DW      = 12,
  parameter int AW      = CORE_AW + 3,
  parameter int MODE_W  = $clog2(AW - CORE_AW + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              mode_err
);

  localparam int MAX_MODE = AW - CORE_AW;
  localparam int EW       = index_bits(MAX_MODE + 1);
  localparam int LW       = (MAX_MODE > 0) ? MAX_MODE : 1;

  if (AW < CORE_AW || (DW >> MAX_MODE) < 1) begin : g_bad_cfg
    $error("fracram_top: AW must lie between CORE_AW and CORE_AW+floor(log2(DW))");
  end

  // Mode decode: clamp illegal codes to the narrowest mode.
  logic          mode_illegal;
  logic [EW-1:0] eff_mode;

  always_comb begin
    mode_illegal = int'(cfg_mode) > MAX_MODE;
    eff_mode     = mode_illegal ? EW'(MAX_MODE) : EW'(cfg_mode);
  end

  always_ff @(posedge clk) begin
    if (rst) mode_err <= 1'b0;
    else     mode_err <= mode_illegal;
  end

  // Address split for both ports.
  logic [CORE_AW-1:0] w_row, r_row;
  logic [LW-1:0]      w_lane, r_lane;

  fracram_addr_split #(.AW(AW), .CORE_AW(CORE_AW), .EW(EW), .LW(LW)) u_wsplit (
    .addr(wr_addr), .mode(eff_mode), .row(w_row), .lane(w_lane)
  );

  fracram_addr_split #(.AW(AW), .CORE_AW(CORE_AW), .EW(EW), .LW(LW)) u_rsplit (
    .addr(rd_addr), .mode(eff_mode), .row(r_row), .lane(r_lane)
  );

  // Write lane placement into a per-bit write enable.
  logic [DW-1:0] core_wmask;
  logic [DW-1:0] core_wdata;

  fracram_wr_lane #(.DW(DW), .MAX_MODE(MAX_MODE), .EW(EW), .LW(LW)) u_wlane (
    .wr_en   (wr_en && !rst),
    .mode    (eff_mode),
    .lane    (w_lane),
    .wr_data (wr_data),
    .bit_we  (core_wmask),
    .bit_data(core_wdata)
  );

  // Physical array.
  logic [DW-1:0] core_rq;

  fracram_core #(.CORE_AW(CORE_AW), .DW(DW)) u_core (
    .clk   (clk),
    .rst   (rst),
    .bit_we(core_wmask),
    .waddr (w_row),
    .wdata (core_wdata),
    .re    (rd_en),
    .raddr (r_row),
    .rq    (core_rq)
  );

  // Lane index travels with the read through the array register.
  logic [LW-1:0] r_lane_q;

  always_ff @(posedge clk) begin
    if (rst)        r_lane_q <= '0;
    else if (rd_en) r_lane_q <= r_lane;
  end

  fracram_rd_lane #(.DW(DW), .MAX_MODE(MAX_MODE), .EW(EW), .LW(LW)) u_rlane (
    .mode     (eff_mode),
    .lane     (r_lane_q),
    .row_data (core_rq),
    .lane_data(rd_data)
  );

endmodule

// File: rtl/fracram_chk.sv
module fracram_chk #(
  parameter int CORE_AW = 4,
  parameter int DW      = 12,
  parameter int AW      = 7,
  parameter int MODE_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] cfg_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DW-1:0]     rd_data,
  input logic              mode_err,
  input logic [DW-1:0]     wmask
);

  localparam int MAX_MODE = AW - CORE_AW;

  int   k_eff;
  int   w_eff;
  int   used_bits;
  logic past_ok;

  always_comb begin
    k_eff     = (int'(cfg_mode) > MAX_MODE) ? MAX_MODE : int'(cfg_mode);
    w_eff     = DW >> k_eff;
    used_bits = w_eff << k_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R9
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !mode_err));

  // R8
  p_err_flag_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (mode_err == (int'($past(cfg_mode)) > MAX_MODE)));

  // R4
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rd_en) && $stable(cfg_mode)) |-> $stable(rd_data));

  // R5
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((rd_data >> w_eff) == '0));

  // R3
  p_lane_width_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(wmask) == w_eff));

  // R6
  p_top_bits_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wmask >> used_bits) == '0));

  // R10
  p_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wmask == '0));

endmodule

bind fracram_top fracram_chk #(
  .CORE_AW(CORE_AW), .DW(DW), .AW(AW), .MODE_W(MODE_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_mode(cfg_mode),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .mode_err(mode_err),
  .wmask   (core_wmask)
);

// File: tb/fracram_top_bench.sv
`timescale 1ns/1ps
module fracram_top_bench;

  localparam int CORE_AW  = 4;
  localparam int DW       = 12;
  localparam int AW       = 7;
  localparam int MODE_W   = 3;
  localparam int MAX_MODE = AW - CORE_AW;
  localparam int ROWS     = 1 << CORE_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [MODE_W-1:0] cfg_mode = '0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic              rd_en = 1'b0;
  logic [AW-1:0]     rd_addr = '0;
  logic [DW-1:0]     rd_data;
  logic              mode_err;

  fracram_top #(.CORE_AW(CORE_AW), .DW(DW), .AW(AW), .MODE_W(MODE_W)) u_fracram_top (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .mode_err(mode_err)
  );

  always #2 clk = ~clk;

  // Reference model state
  logic [DW-1:0] ref_mem [ROWS];
  logic [DW-1:0] exp_rd  = '0;
  logic          exp_err = 1'b0;
  int            checks  = 0;
  int            errors  = 0;
  string         cur_req = "R9";
  bit            done    = 1'b0;

  function automatic int eff(input int m);
    return (m > MAX_MODE) ? MAX_MODE : m;
  endfunction

  function automatic int wid(input int k);
    return DW >> k;
  endfunction

  function automatic int row_of(input int a, input int k);
    return (a >> k) % ROWS;
  endfunction

  function automatic int lane_of(input int a, input int k);
    return a % (1 << k);
  endfunction

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // One clock: update the model at the edge, compare at the falling edge.
  task automatic cycle();
    @(posedge clk);
    if (rst) begin
      exp_rd  = '0;
      exp_err = 1'b0;
    end else begin
      int k = eff(int'(cfg_mode));
      int w = wid(k);
      exp_err = int'(cfg_mode) > MAX_MODE;
      if (rd_en) begin
        int r = row_of(int'(rd_addr), k);
        int l = lane_of(int'(rd_addr), k);
        exp_rd = '0;
        for (int b = 0; b < w; b++) exp_rd[b] = ref_mem[r][l*w+b];
      end
      if (wr_en) begin
        int r = row_of(int'(wr_addr), k);
        int l = lane_of(int'(wr_addr), k);
        for (int b = 0; b < w; b++) ref_mem[r][l*w+b] = wr_data[b];
      end
    end
    @(negedge clk);
    check(cur_req, "rd_data", rd_data, exp_rd);
    check(cur_req, "mode_err", DW'(mode_err), DW'(exp_err));
  endtask

  task automatic op(input bit we, input int wa, input int wd, input bit re, input int ra);
    wr_en   = we;
    wr_addr = AW'(wa);
    wr_data = DW'(wd);
    rd_en   = re;
    rd_addr = AW'(ra);
    cycle();
  endtask

  // Mode changes always come with a read so the held output is refreshed.
  task automatic set_mode(input int m);
    cfg_mode = MODE_W'(m);
    op(0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset with an illegal mode and reads requested
    cur_req  = "R9";
    cfg_mode = MODE_W'(5);
    rd_en    = 1'b1;
    @(negedge clk);
    repeat (3) cycle();
    rst = 1'b0;
    cfg_mode = '0;

    // R1: fill every row in full-width mode and read it back
    cur_req = "R1";
    set_mode(0);
    for (int r = 0; r < ROWS; r++) op(1, r, r * 263 + 17, 0, 0);
    for (int r = 0; r < ROWS; r++) op(0, 0, 0, 1, r);

    // R2: lane placement in mode 1, confirmed by a full-row read
    cur_req = "R2";
    set_mode(1);
    op(1, 5*2 + 1, 'h2A, 0, 0);
    op(0, 0, 0, 1, 5*2 + 1);
    op(0, 0, 0, 1, 5*2);
    set_mode(0);
    op(0, 0, 0, 1, 5);

    // R3: lane-by-lane writes in mode 2 with reads of neighbours between
    cur_req = "R3";
    set_mode(2);
    for (int l = 0; l < 4; l++) begin
      op(1, 7*4 + l, l + 3, 0, 0);
      for (int j = 0; j < 4; j++) op(0, 0, 0, 1, 7*4 + j);
    end
    set_mode(0);
    op(0, 0, 0, 1, 7);
    op(0, 0, 0, 1, 6);
    op(0, 0, 0, 1, 8);

    // R5: upper bits of a narrow read are zero
    cur_req = "R5";
    set_mode(2);
    op(0, 0, 0, 1, 7*4 + 2);
    check("R5", "upper rd_data", rd_data >> 3, '0);

    // R6: narrowest mode leaves the top four row bits alone
    cur_req = "R6";
    set_mode(0);
    op(1, 9, 'hA00, 0, 0);
    set_mode(3);
    for (int l = 0; l < 8; l++) op(1, 9*8 + l, 'hFFF, 0, 0);
    set_mode(0);
    op(0, 0, 0, 1, 9);
    check("R6", "row 9 after narrow writes", rd_data, 12'hAFF);

    // R7: read and write of the same address at the same edge
    cur_req = "R7";
    set_mode(1);
    op(0, 0, 0, 1, 3*2);
    op(1, 3*2, 'h15, 1, 3*2);
    op(0, 0, 0, 1, 3*2);
    check("R7", "value after collision", rd_data, 12'h015);

    // R10 and R4: disabled write, then a held output
    cur_req = "R10";
    op(0, 4*2, 'h3F, 1, 4*2);
    op(0, 0, 0, 1, 4*2);
    cur_req = "R4";
    op(0, 0, 0, 1, 2*2 + 1);
    for (int i = 0; i < 4; i++) op(0, 0, 0, 0, i * 9);

    // R1: high address bits ignored in mode 1 (5-bit logical address)
    cur_req = "R1";
    op(1, 'h60 | 11, 'h2C, 0, 0);
    op(0, 0, 0, 1, 11);
    check("R1", "alias read", rd_data, 12'h02C);
    op(0, 0, 0, 1, 'h20 | 11);

    // R8: illegal code behaves as the narrowest mode and flags it
    cur_req = "R8";
    set_mode(6);
    check("R8", "mode_err raised", DW'(mode_err), DW'(1));
    op(1, 2*8 + 5, 'h1, 1, 2*8 + 5);
    op(0, 0, 0, 1, 2*8 + 5);
    set_mode(3);
    check("R8", "mode_err cleared", DW'(mode_err), DW'(0));
    op(0, 0, 0, 1, 2*8 + 5);

    // R4: random traffic in every mode, including an illegal one
    cur_req = "R4";
    for (int m = 0; m <= MAX_MODE + 1; m++) begin
      set_mode(m == MAX_MODE + 1 ? 7 : m);
      for (int i = 0; i < 150; i++) begin
        int a = int'($urandom_range(0, (1 << AW) - 1));
        op(bit'($urandom_range(0, 1)), a, int'($urandom_range(0, 4095)),
           bit'($urandom_range(0, 1)), (i % 3 == 0) ? a : int'($urandom_range(0, (1 << AW) - 1)));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule